// File: doc/BRIEF.md
# Parallel NOR Page-Mode Read Controller

This block sits on the host side of an asynchronous parallel NOR flash that supports page-mode reads. Read requests come in on a valid/ready pair, each carrying a byte-granular address. The controller drives the chip-enable, output-enable and write-enable strobes and the word address. It waits a programmed number of clock cycles, samples the data bus, and returns the result with a one-cycle valid strobe. No command sequence is needed before the first read, because the flash powers up ready to read its array.

A page is eight words, or sixteen bytes on an 8-bit bus. While chip-enable stays low, the controller remembers the open page. A request whose upper address bits match that page waits only the short intra-page time. Any other request waits the full access time. The page is forgotten in three cases: the bus width input changes, chip-enable is released, or no request arrives for a configurable number of idle cycles, which also releases chip-enable.

On an 8-bit bus, only the low data lane carries data. The least significant byte address bit is driven out on the pin that is data bit 15 in 16-bit mode.

Top module: `nor_page_reader`

## Requirements
- R1: During and right after reset, chip-enable, output-enable and write-enable are high, rsp_valid is low and req_ready is high.
- R2: Write-enable stays high at all times. Output-enable is low only while chip-enable is low.
- R3: The first access after chip-enable was high waits max(T_FULL, T_OE) cycles. Latency is counted from the clock edge that accepts the request to the edge that raises rsp_valid.
- R4: A request whose address bits [AW:4] match the open page, with the bus width unchanged and chip-enable held low, waits max(T_PAGE, T_OE) cycles.
- R5: A request to a different page while chip-enable is low waits max(T_FULL, T_OE) cycles.
- R6: After IDLE_TO consecutive idle cycles in the open-page state, chip-enable rises and the next access is a full access. With IDLE_TO-1 idle cycles, the page stays open.
- R7: Any change of byte_mode closes the page, so the next access waits max(T_FULL, T_OE).
- R8: In 16-bit mode (byte_mode=0), fl_addr carries req_addr[AW:1] during the access and rsp_data returns all 16 data lines.
- R9: In 8-bit mode (byte_mode=1), fl_dq15_oe is high and fl_dq15_out carries req_addr[0] during the access. rsp_data is {8'h00, data[7:0]}.
- R10: req_ready is low for the whole access. Exactly one single-cycle rsp_valid pulse follows each accepted request.
- R11: Address, chip-enable and output-enable stay stable from the accepting edge until the sampling edge, so data is never sampled before the required wait has passed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| byte_mode | input | 1 | 1 = 8-bit flash bus, 0 = 16-bit |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Request is accepted on this edge when valid |
| req_addr | input | AW+1 | Byte address; bit 0 is ignored in 16-bit mode |
| rsp_valid | output | 1 | One-cycle strobe for returned data |
| rsp_data | output | 16 | Read data, zero-extended in 8-bit mode |
| fl_ce_n | output | 1 | Flash chip-enable, active low |
| fl_oe_n | output | 1 | Flash output-enable, active low |
| fl_we_n | output | 1 | Flash write-enable, held high |
| fl_addr | output | AW | Flash word address |
| fl_dq_in | input | 16 | Flash data bus, input side |
| fl_dq15_out | output | 1 | Low byte address bit driven on data bit 15 in 8-bit mode |
| fl_dq15_oe | output | 1 | Output enable for fl_dq15_out |

## Verification
The bench builds the controller with AW=10, T_FULL=7, T_PAGE=3, T_OE=2 and IDLE_TO=4. With these values the page wait is longer than the output-enable wait, so a hit (3 cycles) and a miss (7 cycles) are clearly different and neither is masked by T_OE. The short idle limit puts both sides of the timeout boundary, three idle cycles versus four, within a few cycles. The small address space lets a pseudo-random sweep revisit pages often. The flash model tracks its own page and settle times and returns a poison value until they are met, so early sampling shows up as wrong data.

// File: rtl/nor_rd_pkg.sv
package nor_rd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACC  = 2'd1,
    ST_OPEN = 2'd2
  } rd_state_e;

  // Cycles between the accepting edge and the sampling edge.
  function automatic int unsigned wait_cycles(input logic hit, input int unsigned full_c,
                                              input int unsigned page_c, input int unsigned oe_c);
    int unsigned addr_c;
    addr_c = hit ? page_c : full_c;
    return (addr_c > oe_c) ? addr_c : oe_c;
  endfunction

  // Data lane selection for the returned word.
  function automatic logic [15:0] lane_select(input logic byte_m, input logic [15:0] dq);
    return byte_m ? {8'h00, dq[7:0]} : dq;
  endfunction

endpackage

// File: rtl/nor_wait_timer.sv
module nor_wait_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/nor_idle_timer.sv
module nor_idle_timer #(
  parameter int IDLE_TO = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_open,
  input  logic accept,
  output logic expire
);
  localparam int IW = $clog2(IDLE_TO + 1);
  localparam logic [IW-1:0] LAST = IW'(IDLE_TO - 1);

  logic [IW-1:0] cnt_q;

  assign expire = in_open && !accept && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt_q <= '0;
    else if (!in_open || accept)   cnt_q <= '0;
    else if (expire)               cnt_q <= '0;
    else                           cnt_q <= cnt_q + 1'b1;
  end

  // R6: the timer never runs past its limit
  a_r6_idle_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
endmodule

// File: rtl/nor_page_tracker.sv
module nor_page_tracker #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode,
  input  logic [TW-1:0] tag_in,
  input  logic          load,
  input  logic          drop,
  output logic          hit
);
  logic          valid_q;
  logic          mode_q;
  logic [TW-1:0] tag_q;
  logic          mode_moved;

  assign mode_moved = (mode != mode_q);
  assign hit        = valid_q && !mode_moved && (tag_q == tag_in);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      mode_q  <= 1'b0;
      tag_q   <= '0;
    end else begin
      mode_q <= mode;
      if (drop)            valid_q <= 1'b0;
      else if (load)       valid_q <= 1'b1;
      else if (mode_moved) valid_q <= 1'b0;
      if (load)            tag_q   <= tag_in;
    end
  end

  // R7: a width change seen at the port never yields a page hit
  a_r7_mode_flush: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != $past(mode)) |-> !hit);
endmodule

// File: rtl/nor_page_reader.sv
module nor_page_reader #(
  parameter int AW      = 24,
  parameter int T_FULL  = 10,
  parameter int T_PAGE  = 4,
  parameter int T_OE    = 3,
  parameter int IDLE_TO = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          byte_mode,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW:0]   req_addr,
  output logic          rsp_valid,
  output logic [15:0]   rsp_data,
  output logic          fl_ce_n,
  output logic          fl_oe_n,
  output logic          fl_we_n,
  output logic [AW-1:0] fl_addr,
  input  logic [15:0]   fl_dq_in,
  output logic          fl_dq15_out,
  output logic          fl_dq15_oe
);
  import nor_rd_pkg::*;

  localparam int TW      = AW - 3;
  localparam int W_MISS  = wait_cycles(1'b0, T_FULL, T_PAGE, T_OE);
  localparam int W_HIT   = wait_cycles(1'b1, T_FULL, T_PAGE, T_OE);
  localparam int W_MAX   = (W_MISS > W_HIT) ? W_MISS : W_HIT;
  localparam int CW      = $clog2(W_MAX + 1);
  localparam logic [CW-1:0] LD_MISS = CW'(W_MISS - 1);
  localparam logic [CW-1:0] LD_HIT  = CW'(W_HIT - 1);

  rd_state_e state_q;
  logic      accept;
  logic      page_hit;
  logic      sample_now;
  logic      idle_close;
  logic      timer_done;
  logic      mode_acc_q;

  assign req_ready  = (state_q != ST_ACC);
  assign accept     = req_valid && req_ready;
  assign sample_now = (state_q == ST_ACC) && timer_done;
  assign fl_we_n    = 1'b1;
  assign fl_dq15_oe = byte_mode;

  nor_page_tracker #(.TW(TW)) u_track (
    .clk    (clk),
    .rst_n  (rst_n),
    .mode   (byte_mode),
    .tag_in (req_addr[AW:4]),
    .load   (accept),
    .drop   (idle_close),
    .hit    (page_hit)
  );

  nor_wait_timer #(.CW(CW)) u_wait (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .load_val (page_hit ? LD_HIT : LD_MISS),
    .expired  (timer_done)
  );

  nor_idle_timer #(.IDLE_TO(IDLE_TO)) u_idle (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_open (state_q == ST_OPEN),
    .accept  (accept),
    .expire  (idle_close)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      fl_ce_n     <= 1'b1;
      fl_oe_n     <= 1'b1;
      fl_addr     <= '0;
      fl_dq15_out <= 1'b0;
      mode_acc_q  <= 1'b0;
      rsp_valid   <= 1'b0;
      rsp_data    <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (accept) begin
        state_q     <= ST_ACC;
        fl_ce_n     <= 1'b0;
        fl_oe_n     <= 1'b0;
        fl_addr     <= req_addr[AW:1];
        fl_dq15_out <= req_addr[0];
        mode_acc_q  <= byte_mode;
      end else if (sample_now) begin
        state_q   <= ST_OPEN;
        fl_oe_n   <= 1'b1;
        rsp_valid <= 1'b1;
        rsp_data  <= lane_select(mode_acc_q, fl_dq_in);
      end else if (idle_close) begin
        state_q <= ST_IDLE;
        fl_ce_n <= 1'b1;
      end
    end
  end

  a_r2_we_high: assert property (@(posedge clk) disable iff (!rst_n)
    fl_we_n);
  a_r2_oe_under_ce: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_oe_n |-> !fl_ce_n);
  a_r3_ce_release_drops_page: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fl_ce_n) |-> !page_hit);
  a_r10_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ACC) |-> !req_ready);
  a_r10_rsp_single: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  a_r11_hold_during_access: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ACC && $past(state_q) == ST_ACC) |-> ($stable(fl_addr) && !fl_oe_n && !fl_ce_n));
endmodule

// File: tb/nor_page_reader_tb.sv
module nor_page_reader_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 10, T_FULL = 7, T_PAGE = 3, T_OE = 2, IDLE_TO = 4;
  localparam int W_MISS = (T_FULL > T_OE) ? T_FULL : T_OE;
  localparam int W_HIT  = (T_PAGE > T_OE) ? T_PAGE : T_OE;

  logic clk = 0, rst_n = 0, byte_mode = 0, req_valid = 0;
  logic [AW:0] req_addr = '0;
  logic req_ready, rsp_valid, fl_ce_n, fl_oe_n, fl_we_n, fl_dq15_out, fl_dq15_oe;
  logic [15:0] rsp_data, fl_dq;
  logic [AW-1:0] fl_addr;

  nor_page_reader #(.AW(AW), .T_FULL(T_FULL), .T_PAGE(T_PAGE), .T_OE(T_OE), .IDLE_TO(IDLE_TO)) u_dut (
    .clk(clk), .rst_n(rst_n), .byte_mode(byte_mode), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_data(rsp_data), .fl_ce_n(fl_ce_n),
    .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n), .fl_addr(fl_addr), .fl_dq_in(fl_dq),
    .fl_dq15_out(fl_dq15_out), .fl_dq15_oe(fl_dq15_oe));

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0, total = 0, bad = 0, exp_rsp = -1, last_rsp = -1000;
  bit ref_open = 0, ref_mode = 0, mode_flip = 0, finished = 0;
  logic [AW-4:0] ref_tag = '0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [15:0] mem_word(input logic [AW-1:0] wa);
    logic [31:0] p;
    p = 32'(wa) * 32'h9E37;
    return p[15:0] ^ 16'h5A5A;
  endfunction

  function automatic logic [7:0] mem_byte(input logic [AW:0] ba);
    logic [15:0] w;
    w = mem_word(ba[AW:1]);
    return ba[0] ? w[15:8] : w[7:0];
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Behavioural flash: poison until its own settle times are met.
  int c_pg = 0, c_lo = 0, c_oe = 0;
  logic prev_ce_n = 1, prev_oe_n = 1;
  logic [AW-3:0] prev_hi = '0;
  logic [3:0] prev_lo = '0;
  always @(negedge clk) begin
    logic [AW-3:0] hi;
    logic [3:0] lo;
    hi = {byte_mode, fl_addr[AW-1:3]};
    lo = {fl_addr[2:0], byte_mode & fl_dq15_out};
    if (fl_ce_n) begin
      c_pg = 0; c_lo = 0; c_oe = 0;
    end else begin
      if (prev_ce_n || hi != prev_hi) begin c_pg = 1; c_lo = 1; end
      else begin c_pg++; c_lo = (lo != prev_lo) ? 1 : c_lo + 1; end
      c_oe = fl_oe_n ? 0 : (prev_oe_n ? 1 : c_oe + 1);
    end
    prev_ce_n = fl_ce_n; prev_oe_n = fl_oe_n; prev_hi = hi; prev_lo = lo;
    if (!fl_ce_n && !fl_oe_n && c_oe >= T_OE && c_pg >= T_FULL && c_lo >= T_PAGE)
      fl_dq = byte_mode ? {8'hA5, mem_byte({fl_addr, fl_dq15_out})} : mem_word(fl_addr);
    else
      fl_dq = 16'hDEAD;
  end

  // Every-clock comparison against the reference schedule.
  always @(negedge clk) if (rst_n && !finished) begin
    if (!fl_we_n) chk(0, "R2", "write-enable low", 0, 1);
    if (!fl_oe_n && fl_ce_n) chk(0, "R2", "oe low with ce high", 1, 0);
    if (rsp_valid && cyc != exp_rsp) chk(0, "R10", "unexpected rsp_valid cycle", cyc, exp_rsp);
  end

  task automatic set_mode(input logic m);
    @(negedge clk);
    #1 byte_mode = m;
    mode_flip = 1;
  endtask

  task automatic do_read(input logic [AW:0] a, input string rq);
    int acc, gap, w, guard;
    bit hit;
    logic [15:0] exp_d;
    @(negedge clk);
    req_valid = 1; req_addr = a;
    while (!req_ready) @(negedge clk);
    acc = cyc + 1;
    gap = acc - last_rsp - 1;
    hit = ref_open && (a[AW:4] == ref_tag) && (byte_mode == ref_mode) && !mode_flip && (gap < IDLE_TO);
    w = hit ? W_HIT : W_MISS;
    exp_rsp = acc + w;
    exp_d = byte_mode ? {8'h00, mem_byte(a)} : mem_word(a[AW:1]);
    @(negedge clk);
    req_valid = 0;
    chk(!req_ready, "R10", "ready during access", int'(req_ready), 0);
    chk(fl_addr == a[AW:1], "R8", "flash address", int'(fl_addr), int'(a[AW:1]));
    if (byte_mode) begin
      chk(fl_dq15_oe && fl_dq15_out == a[0], "R9", "low address bit pin", int'({fl_dq15_oe, fl_dq15_out}), int'({1'b1, a[0]}));
    end
    guard = 0;
    while (!rsp_valid && guard < 100) begin @(negedge clk); guard++; end
    chk(cyc == exp_rsp, hit ? "R4" : rq, "response latency", cyc - acc, w);
    chk(rsp_data == exp_d, byte_mode ? "R9" : "R8", "read data", int'(rsp_data), int'(exp_d));
    last_rsp = cyc; ref_open = 1; ref_tag = a[AW:4]; ref_mode = byte_mode; mode_flip = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (1000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    idle(2);
    // R1: reset state
    chk(fl_ce_n && fl_oe_n && fl_we_n && !rsp_valid && req_ready, "R1", "reset outputs",
        int'({fl_ce_n, fl_oe_n, fl_we_n, rsp_valid, req_ready}), 5'b11101);
    @(negedge clk); rst_n = 1;
    idle(1);
    chk(fl_ce_n && fl_oe_n && !rsp_valid && req_ready, "R1", "after reset",
        int'({fl_ce_n, fl_oe_n, rsp_valid, req_ready}), 4'b1101);
    // R3 first access, R4 hits, R5 page change
    do_read(11'h010, "R3");
    do_read(11'h014, "R4");
    do_read(11'h01E, "R4");
    do_read(11'h020, "R5");
    do_read(11'h022, "R4");
    // R6 idle timeout closes chip-enable
    idle(IDLE_TO + 2);
    chk(fl_ce_n, "R6", "ce released after idle", int'(fl_ce_n), 1);
    do_read(11'h024, "R6");
    idle(IDLE_TO - 2);            // gap IDLE_TO-1: still a hit
    do_read(11'h026, "R6");
    idle(IDLE_TO - 1);            // gap IDLE_TO: closed
    do_read(11'h028, "R6");
    // R7 width change flushes; R9 byte mode
    set_mode(1'b1);
    do_read(11'h029, "R7");
    chk(fl_dq15_oe, "R9", "dq15 driven in byte mode", int'(fl_dq15_oe), 1);
    do_read(11'h02B, "R9");
    do_read(11'h02C, "R9");
    set_mode(1'b0);
    do_read(11'h02E, "R7");
    chk(!fl_dq15_oe, "R8", "dq15 released in word mode", int'(fl_dq15_oe), 0);
    // R11 mixed sweep with varied gaps and widths
    lfsr = 16'hACE1;
    for (int i = 0; i < 40; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[9:8] == 2'b11) set_mode(~byte_mode);
      idle(int'(lfsr[12:10]) % 6);
      do_read(lfsr[11] ? {ref_tag, lfsr[3:0]} : lfsr[AW:0], "R11");
    end
    idle(3);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule